// File: doc/BRIEF.md
# Serial Audio Link Frame Receiver and Command Decoder

This block sits on the codec side of a serial audio link. Each frame is 256 bits long and carries a 16-bit tag slot followed by twenty-bit slots. The block watches a bit clock, a frame sync line and a serial data line, all sampled in its own system clock domain. It captures one data bit on every falling edge of the bit clock. A rising edge on the sync line, seen between two such samples, marks the first tag bit of a new frame.

From each frame the block reads the tag and the first four data slots. It turns them into single-cycle events: a register read or write request with a word index and sixteen bits of write data, and left and right PCM samples, each with its own strobe. The tag bits gate every event. A frame whose frame-valid flag is clear produces nothing, and a slot whose valid flag is clear is skipped. Reserved bits and slots 5 to 12 never reach the outputs.

A sync edge that arrives before the 256th bit abandons the partial frame. It also raises a sticky framing-error flag, which only reset clears.

Top module: `linkframe_rx`

## Requirements
- R1: While reset is asserted and right after it is released, every output is zero: no strobe, no request, zero data fields and a clear error flag.
- R2: A bit is taken only when the bit clock falls. The bit taken when sync is seen high after being low at the previous sample is bit 0, the tag MSB. Bits taken before the first such edge produce no event.
- R3: When tag bit 15 (frame valid) is clear, the frame produces no request and no PCM strobe, whatever its other valid bits say.
- R4: When tag bits 15 and 14 are set and slot 1 bit 19 is 1, `reg_rd_o` pulses right after the last bit of slot 2 (frame bit 55). `reg_idx_o` then carries slot 1 bits 18 to 13, with bit 18 as the MSB.
- R5: When tag bits 15, 14 and 13 are set and slot 1 bit 19 is 0, `reg_wr_o` pulses after frame bit 55 with `reg_wdata_o` equal to slot 2 bits 19 to 4. With bit 13 clear, no write occurs. Read and write never pulse together.
- R6: Slot 1 bits 12 to 0, slot 2 bits 3 to 0 and tag bits 10 to 0 have no effect on any output.
- R7: When tag bits 15 and 12 are set, `pcm_l_stb_o` pulses right after frame bit 75, and `pcm_l_o` holds slot 3 MSB-aligned.
- R8: When tag bits 15 and 11 are set, `pcm_r_stb_o` pulses right after frame bit 95, and `pcm_r_o` holds slot 4 MSB-aligned.
- R9: Slots 5 to 12 and any bits after the 256th bit that arrive before the next sync edge have no effect on any output.
- R10: A sync edge after fewer than 256 bits of the current frame sets `frame_err_o`, which stays set until reset. That frame's slots not yet complete produce no event. A sync edge after exactly 256 or more bits leaves the flag unchanged.
- R11: Every strobe lasts one clock. Each data output holds its value until its next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Link bit clock, synchronous to clk_i |
| sync_i | input | 1 | Frame sync |
| sdata_i | input | 1 | Serial frame data |
| reg_rd_o | output | 1 | Register read request pulse |
| reg_wr_o | output | 1 | Register write request pulse |
| reg_idx_o | output | IDX_W | Word index of the request |
| reg_wdata_o | output | DATA_W | Write data |
| pcm_l_stb_o | output | 1 | Left sample strobe |
| pcm_l_o | output | PCM_W | Left sample, MSB-aligned |
| pcm_r_stb_o | output | 1 | Right sample strobe |
| pcm_r_o | output | PCM_W | Right sample, MSB-aligned |
| frame_err_o | output | 1 | Sticky framing error |

## Verification
A bit counter that is off by even one position shifts every field. The index, write data and samples come out with neighbouring bits, and the strobe lands one bit period early or late, so the first valid frame after the fault shows it. A stale or wrongly captured tag shows up on the next frame as a missing or extra strobe at bit 55, 75 or 95. A framing flag that is set or cleared wrongly differs at the port from the sync edge onward and never recovers. The bench compares every output on every clock against a behavioural model, so any of these faults is caught within one frame.

// File: rtl/lfr_pkg.sv
package lfr_pkg;
   typedef struct packed {
      logic fv;
      logic v1;
      logic v2;
      logic v3;
      logic v4;
   } tag_t;

   localparam int DEF_FRAME_BITS = 256;
   localparam int DEF_TAG_W      = 16;
   localparam int DEF_SLOT_W     = 20;
endpackage

// File: rtl/lfr_bit_sampler.sv
module lfr_bit_sampler (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic bclk_i,
   input  logic sync_i,
   input  logic sdata_i,
   output logic take_o,
   output logic start_o,
   output logic bit_o
);
   logic bclk_q;
   logic sync_q;

   assign take_o  = bclk_q & ~bclk_i;
   assign start_o = take_o & sync_i & ~sync_q;
   assign bit_o   = sdata_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bclk_q <= 1'b0;
         sync_q <= 1'b0;
      end else begin
         bclk_q <= bclk_i;
         if (take_o) sync_q <= sync_i;
      end
   end

   // R2
   start_needs_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_o |=> !start_o);
endmodule

// File: rtl/lfr_framer.sv
module lfr_framer #(
   parameter int FRAME_BITS = 256,
   parameter int SLOT_W     = 20,
   parameter int CNT_W      = 9
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              take_i,
   input  logic              start_i,
   input  logic              bit_i,
   output logic              acc_o,
   output logic [CNT_W-1:0]  pos_o,
   output logic [SLOT_W-1:0] word_o,
   output logic              err_o
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

   logic [CNT_W-1:0]  cnt_q;
   logic [SLOT_W-2:0] shift_q;
   logic              locked_q;
   logic              err_q;

   assign acc_o  = take_i & (start_i | (locked_q & (cnt_q < FULL)));
   assign pos_o  = start_i ? '0 : cnt_q;
   assign word_o = {shift_q, bit_i};
   assign err_o  = err_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q    <= '0;
         shift_q  <= '0;
         locked_q <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         if (start_i) begin
            locked_q <= 1'b1;
            if (locked_q && cnt_q != FULL) err_q <= 1'b1;
         end
         if (acc_o) begin
            cnt_q   <= pos_o + 1'b1;
            shift_q <= word_o[SLOT_W-2:0];
         end
      end
   end

   // R10
   err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_q |=> err_q);

   // R9
   cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= FULL);
endmodule

// File: rtl/lfr_slot_decode.sv
module lfr_slot_decode #(
   parameter int TAG_W  = 16,
   parameter int SLOT_W = 20,
   parameter int CNT_W  = 9,
   parameter int IDX_W  = 6,
   parameter int DATA_W = 16,
   parameter int PCM_W  = 20
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              acc_i,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  pos_i,
   input  logic [SLOT_W-1:0] word_i,
   output logic              rd_o,
   output logic              wr_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              l_stb_o,
   output logic [PCM_W-1:0]  l_o,
   output logic              r_stb_o,
   output logic [PCM_W-1:0]  r_o
);
   import lfr_pkg::*;

   localparam logic [CNT_W-1:0] POS_TAG = CNT_W'(TAG_W - 1);
   localparam logic [CNT_W-1:0] POS_S1  = CNT_W'(TAG_W + SLOT_W - 1);
   localparam logic [CNT_W-1:0] POS_S2  = CNT_W'(TAG_W + 2*SLOT_W - 1);
   localparam logic [CNT_W-1:0] POS_S3  = CNT_W'(TAG_W + 3*SLOT_W - 1);
   localparam logic [CNT_W-1:0] POS_S4  = CNT_W'(TAG_W + 4*SLOT_W - 1);

   tag_t             tag_q;
   logic             rw_q;
   logic [IDX_W-1:0] cidx_q;
   logic [PCM_W-1:0] pcm_w;

   if (PCM_W == SLOT_W) begin : g_pcm_full
      assign pcm_w = word_i;
   end else begin : g_pcm_trunc
      assign pcm_w = word_i[SLOT_W-1 -: PCM_W];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tag_q   <= '0;
         rw_q    <= 1'b0;
         cidx_q  <= '0;
         rd_o    <= 1'b0;
         wr_o    <= 1'b0;
         idx_o   <= '0;
         wdata_o <= '0;
         l_stb_o <= 1'b0;
         l_o     <= '0;
         r_stb_o <= 1'b0;
         r_o     <= '0;
      end else begin
         rd_o    <= 1'b0;
         wr_o    <= 1'b0;
         l_stb_o <= 1'b0;
         r_stb_o <= 1'b0;
         if (start_i) tag_q <= '0;
         if (acc_i) begin
            if (pos_i == POS_TAG) tag_q <= tag_t'(word_i[TAG_W-1 -: 5]);
            if (pos_i == POS_S1) begin
               rw_q   <= word_i[SLOT_W-1];
               cidx_q <= word_i[SLOT_W-2 -: IDX_W];
            end
            if (pos_i == POS_S2 && tag_q.fv && tag_q.v1) begin
               if (rw_q) begin
                  rd_o  <= 1'b1;
                  idx_o <= cidx_q;
               end else if (tag_q.v2) begin
                  wr_o    <= 1'b1;
                  idx_o   <= cidx_q;
                  wdata_o <= word_i[SLOT_W-1 -: DATA_W];
               end
            end
            if (pos_i == POS_S3 && tag_q.fv && tag_q.v3) begin
               l_stb_o <= 1'b1;
               l_o     <= pcm_w;
            end
            if (pos_i == POS_S4 && tag_q.fv && tag_q.v4) begin
               r_stb_o <= 1'b1;
               r_o     <= pcm_w;
            end
         end
      end
   end

   // R5
   rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rd_o && wr_o));

   // R11
   l_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      l_stb_o |=> !l_stb_o);

   // R11
   r_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      r_stb_o |=> !r_stb_o);

   // R11
   l_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !l_stb_o |-> $stable(l_o));

   // R3
   ev_needs_fv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_o || wr_o || l_stb_o || r_stb_o) |-> tag_q.fv);
endmodule

// File: rtl/linkframe_rx.sv
module linkframe_rx #(
   parameter int FRAME_BITS = lfr_pkg::DEF_FRAME_BITS,
   parameter int TAG_W      = lfr_pkg::DEF_TAG_W,
   parameter int SLOT_W     = lfr_pkg::DEF_SLOT_W,
   parameter int IDX_W      = 6,
   parameter int DATA_W     = 16,
   parameter int PCM_W      = 20
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bclk_i,
   input  logic              sync_i,
   input  logic              sdata_i,
   output logic              reg_rd_o,
   output logic              reg_wr_o,
   output logic [IDX_W-1:0]  reg_idx_o,
   output logic [DATA_W-1:0] reg_wdata_o,
   output logic              pcm_l_stb_o,
   output logic [PCM_W-1:0]  pcm_l_o,
   output logic              pcm_r_stb_o,
   output logic [PCM_W-1:0]  pcm_r_o,
   output logic              frame_err_o
);
   localparam int CNT_W = $clog2(FRAME_BITS + 1);

   if (FRAME_BITS < TAG_W + 4*SLOT_W) begin : g_bad_frame
      $error("frame too short for tag and four slots");
   end
   if (SLOT_W < TAG_W || TAG_W < 5) begin : g_bad_tag
      $error("tag width must be 5..SLOT_W");
   end
   if (PCM_W > SLOT_W || DATA_W > SLOT_W || IDX_W > SLOT_W - 2) begin : g_bad_field
      $error("field wider than its slot");
   end

   logic              take, start, sbit, acc;
   logic [CNT_W-1:0]  pos;
   logic [SLOT_W-1:0] word;

   lfr_bit_sampler u_sampler (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .bclk_i  (bclk_i),
      .sync_i  (sync_i),
      .sdata_i (sdata_i),
      .take_o  (take),
      .start_o (start),
      .bit_o   (sbit)
   );

   lfr_framer #(
      .FRAME_BITS (FRAME_BITS),
      .SLOT_W     (SLOT_W),
      .CNT_W      (CNT_W)
   ) u_framer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .take_i  (take),
      .start_i (start),
      .bit_i   (sbit),
      .acc_o   (acc),
      .pos_o   (pos),
      .word_o  (word),
      .err_o   (frame_err_o)
   );

   lfr_slot_decode #(
      .TAG_W  (TAG_W),
      .SLOT_W (SLOT_W),
      .CNT_W  (CNT_W),
      .IDX_W  (IDX_W),
      .DATA_W (DATA_W),
      .PCM_W  (PCM_W)
   ) u_decode (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .acc_i   (acc),
      .start_i (start),
      .pos_i   (pos),
      .word_i  (word),
      .rd_o    (reg_rd_o),
      .wr_o    (reg_wr_o),
      .idx_o   (reg_idx_o),
      .wdata_o (reg_wdata_o),
      .l_stb_o (pcm_l_stb_o),
      .l_o     (pcm_l_o),
      .r_stb_o (pcm_r_stb_o),
      .r_o     (pcm_r_o)
   );
endmodule

// File: tb/linkframe_rx_bench.sv
`timescale 1ns/1ps
module linkframe_rx_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bclk = 1'b0, sync = 1'b0, sd = 1'b0;
   always #2 clk = ~clk;

   logic        rd, wr, ls, rs, err;
   logic [5:0]  idx;
   logic [15:0] wdata;
   logic [19:0] pl, pr;

   linkframe_rx u_linkframe_rx (
      .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .sync_i(sync), .sdata_i(sd),
      .reg_rd_o(rd), .reg_wr_o(wr), .reg_idx_o(idx), .reg_wdata_o(wdata),
      .pcm_l_stb_o(ls), .pcm_l_o(pl), .pcm_r_stb_o(rs), .pcm_r_o(pr),
      .frame_err_o(err)
   );

   int errors = 0, checks = 0;
   int n_rd = 0, n_wr = 0, n_l = 0, n_r = 0;
   bit done = 0;

   task automatic chk(input string req, input bit ok, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference model
   logic        m_frm [0:255];
   int          m_cnt;
   bit          m_locked, m_sync, m_bclk;
   logic        e_rd, e_wr, e_ls, e_rs, e_err;
   logic [5:0]  e_idx;
   logic [15:0] e_wdata;
   logic [19:0] e_l, e_r;

   function automatic logic [19:0] field(input int s, input int n);
      logic [19:0] v = '0;
      for (int i = 0; i < n; i++) v = {v[18:0], m_frm[s+i]};
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_locked = 0; m_sync = 0; m_bclk = 0;
         e_rd = 0; e_wr = 0; e_ls = 0; e_rs = 0; e_err = 0;
         e_idx = 0; e_wdata = 0; e_l = 0; e_r = 0;
      end else begin
         e_rd = 0; e_wr = 0; e_ls = 0; e_rs = 0;
         if (m_bclk && !bclk) begin
            int k;
            k = -1;
            if (sync && !m_sync) begin
               if (m_locked && m_cnt < 256) e_err = 1;
               m_locked = 1;
               k = 0;
            end else if (m_locked && m_cnt < 256) k = m_cnt;
            m_sync = sync;
            if (k >= 0) begin
               m_frm[k] = sd;
               m_cnt = k + 1;
               if (k == 55 && m_frm[0] && m_frm[1]) begin
                  if (m_frm[16]) begin
                     e_rd = 1; e_idx = field(17, 6);
                  end else if (m_frm[2]) begin
                     e_wr = 1; e_idx = field(17, 6); e_wdata = field(36, 16);
                  end
               end
               if (k == 75 && m_frm[0] && m_frm[3]) begin e_ls = 1; e_l = field(56, 20); end
               if (k == 95 && m_frm[0] && m_frm[4]) begin e_rs = 1; e_r = field(76, 20); end
            end
         end
         m_bclk = bclk;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R4 rd",     rd === e_rd, rd, e_rd);
         chk("R5 wr",     wr === e_wr, wr, e_wr);
         chk("R4 idx",    idx === e_idx, idx, e_idx);
         chk("R5 wdata",  wdata === e_wdata, wdata, e_wdata);
         chk("R7 lstb",   ls === e_ls, ls, e_ls);
         chk("R7 left",   pl === e_l, pl, e_l);
         chk("R8 rstb",   rs === e_rs, rs, e_rs);
         chk("R8 right",  pr === e_r, pr, e_r);
         chk("R10 err",   err === e_err, err, e_err);
         if (rd) n_rd++;
         if (wr) n_wr++;
         if (ls) n_l++;
         if (rs) n_r++;
      end
   end

   logic tx [0:255];

   task automatic send_bit(input logic s, input logic d);
      @(negedge clk); bclk = 1; sync = s; sd = d;
      @(negedge clk); @(negedge clk); bclk = 0;
      @(negedge clk);
   endtask

   task automatic send_frame(input logic [15:0] tag, input logic [19:0] s1, s2, s3, s4,
                             input int nbits);
      for (int i = 0; i < 256; i++) tx[i] = ((i * 5) % 7) < 3;
      for (int i = 0; i < 16; i++) tx[i] = tag[15-i];
      for (int i = 0; i < 20; i++) begin
         tx[16+i] = s1[19-i]; tx[36+i] = s2[19-i];
         tx[56+i] = s3[19-i]; tx[76+i] = s4[19-i];
      end
      for (int i = 0; i < nbits; i++) send_bit(i < 16, tx[i]);
   endtask

   task automatic check_outputs_zero(input string req);
      chk(req, {rd, wr, ls, rs, err} == 5'b0 && idx == 0 && wdata == 0 && pl == 0 && pr == 0,
          {rd, wr, ls, rs, err}, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      check_outputs_zero("R1 in reset");
      rst_n = 1;
      @(negedge clk);
      check_outputs_zero("R1 after reset");

      // R2: noise before any sync
      for (int i = 0; i < 24; i++) send_bit(0, i[0]);
      chk("R2 no event before sync", n_rd + n_wr + n_l + n_r == 0, n_rd + n_wr + n_l + n_r, 0);

      // R5 R6 R7 R8: full write frame with junk in ignored bits
      send_frame(16'b11111_01011001110, {1'b0, 7'b1010101, 12'hA5C}, {16'hBEEF, 4'h9},
                 20'hABCDE, 20'h12345, 256);
      chk("R5 write count", n_wr == 1, n_wr, 1);
      chk("R6 index ignores low bits", idx == 6'h2A, idx, 6'h2A);
      chk("R5 write data", wdata == 16'hBEEF, wdata, 16'hBEEF);
      chk("R7 left sample", pl == 20'hABCDE && n_l == 1, pl, 20'hABCDE);
      chk("R8 right sample", pr == 20'h12345 && n_r == 1, pr, 20'h12345);

      // R4: read without slot 2 valid
      send_frame(16'hC000, {1'b1, 7'b0110011, 12'h000}, 20'h0, 20'h0, 20'h0, 256);
      chk("R4 read count", n_rd == 1 && n_wr == 1, n_rd, 1);
      chk("R4 read index", idx == 6'h19, idx, 6'h19);

      // R5: write with slot 2 flag clear is dropped
      send_frame(16'hC000, {1'b0, 7'b1111111, 12'h000}, {16'h5555, 4'h0}, 20'h0, 20'h0, 256);
      chk("R5 write needs slot2 valid", n_wr == 1 && wdata == 16'hBEEF, n_wr, 1);

      // R3: frame valid clear
      send_frame(16'h7800, {1'b1, 7'h11, 12'h0}, 20'hFFFFF, 20'h11111, 20'h22222, 256);
      chk("R3 no events", n_rd + n_wr + n_l + n_r == 4, n_rd + n_wr + n_l + n_r, 4);

      // R8 R11: right only, left held
      send_frame(16'h8800, 20'h0, 20'h0, 20'h77777, 20'hFEDCB, 256);
      chk("R8 right only", pr == 20'hFEDCB && n_r == 2, pr, 20'hFEDCB);
      chk("R11 left held", pl == 20'hABCDE && n_l == 1, pl, 20'hABCDE);

      // R9 R10: overlong frame then another, no error
      send_frame(16'h0000, 20'h0, 20'h0, 20'h0, 20'h0, 256);
      for (int i = 0; i < 12; i++) send_bit(0, 1'b1);
      send_frame(16'h9000, 20'h0, 20'h0, 20'h13579, 20'h0, 256);
      chk("R9 extra bits ignored", pl == 20'h13579 && n_l == 2, pl, 20'h13579);
      chk("R10 no error on full frame", err == 0, err, 0);

      // R10: truncated frame
      send_frame(16'hF800, {1'b0, 7'h02, 12'h0}, {16'h1234, 4'h0}, 20'h2468A, 20'h0, 60);
      chk("R10 slot done before cut", n_wr == 2 && wdata == 16'h1234, wdata, 16'h1234);
      send_frame(16'h0000, 20'h0, 20'h0, 20'h0, 20'h0, 256);
      chk("R10 error set", err == 1, err, 1);
      chk("R10 partial slot dropped", n_l == 2 && pl == 20'h13579, pl, 20'h13579);
      send_frame(16'h0000, 20'h0, 20'h0, 20'h0, 20'h0, 256);
      chk("R10 error sticky", err == 1, err, 1);

      @(negedge clk); rst_n = 0;
      @(negedge clk);
      check_outputs_zero("R1 reset clears error");
      rst_n = 1;
      repeat (4) @(negedge clk);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL R2 watchdog act=0 exp=1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule